// File: doc/BRIEF.md
# Byte-Lane Write Sequencer for Asynchronous Static RAM

This block turns a one-cycle write request into a complete, timing-correct write cycle on an external asynchronous 16-bit static RAM. The RAM has active-low chip select, write strobe, output enable and one active-low enable per byte lane. A request carries an address, 16 bits of data and a per-byte mask. It is taken on a valid/ready handshake. The sequencer then walks a fixed chain of states, counting system-clock cycles so that every minimum analog timing is met. Each count is derived at elaboration from a nanosecond figure and the clock period, rounding up. A single-cycle `done` pulse reports completion.

The write is always ended by the rising edge of the write strobe. Chip select and the selected byte enables stay low for one more clock, so no other edge can end the write. Output enable is held high for the whole time, so the RAM never drives the shared data bus. The block only turns on its own data drivers after the write strobe has been low long enough for the RAM outputs to reach high impedance.

States and transitions:
- IDLE: ready is high. A request with a non-empty mask moves to SETUP. A request with an empty mask stays in IDLE and produces `done` on the next cycle.
- SETUP: one cycle. Chip select and byte enables fall, and the write strobe stays high. Always moves to WE_LOW.
- WE_LOW: the write strobe is low and the drivers are off. After HZ cycles it moves to DRIVE.
- DRIVE: the write strobe is low and the data is driven. After D cycles it moves to RELEASE.
- RELEASE: one cycle. The write strobe rises, while chip select, the byte enables and the data stay put. Always moves to RECOVER.
- RECOVER: all strobes are inactive and the address is held. After Rc cycles it moves to IDLE and pulses `done`.

The counts are derived as follows. HZ = ceil(20 ns / T). D = max(ceil(25 ns / T), ceil(35 ns / T) − HZ). Rc = max(1, ceil(45 ns / T) − 2 − HZ − D).

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `done` is 0, and `sram_ce_n`, `sram_we_n`, `sram_oe_n` and every bit of `sram_be_n` are 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. For a non-empty mask, `req_ready` stays 0 from the cycle after acceptance until the cycle in which `done` is 1.
- R3: Mask bit 0 selects the lower byte: `sram_be_n[0]` goes low and data bits 7:0 are written. Mask bit 1 selects the upper byte: `sram_be_n[1]` goes low and data bits 15:8 are written. The enable of an unselected lane stays 1 for the whole cycle.
- R4: A request whose mask is 0 gives `done`=1 in the cycle right after acceptance, and no strobe goes low.
- R5: The write strobe stays low for at least ceil(35 ns / T) cycles (4 at T = 10 ns). `sram_oe_n` is 1 at all times.
- R6: Chip select and the selected byte enables are low before the write strobe falls. They stay low in the cycle in which the write strobe rises, so the strobe's rising edge is the only edge that ends a write.
- R7: The data drivers stay off for the first ceil(20 ns / T) cycles of the low strobe. The written value is on the bus for at least ceil(25 ns / T) cycles before the strobe rises (3 at T = 10 ns), and it is still there in the cycle after the rise.
- R8: The address is stable while chip select is low. Two successive falling edges of chip select are at least ceil(45 ns / T) cycles apart (5 at T = 10 ns).
- R9: With the default parameters, `done` is 1 exactly 9 clock cycles after the accepting edge of a non-empty request.
- R10: After each request, the RAM word at the request address holds the selected bytes of the request data, and its unselected bytes keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, able to take a request |
| req_addr | input | ADDR_W | Word address of the request |
| req_data | input | 8*LANES | Write data |
| req_mask | input | LANES | Per-byte write select, bit 0 = bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| sram_addr | output | ADDR_W | RAM address, held from acceptance to the next acceptance |
| sram_dq | inout | 8*LANES | RAM data bus, driven only in DRIVE and RELEASE |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, held high |
| sram_be_n | output | LANES | RAM byte enables, active low, bit 0 = lower byte |

## Verification
The bench models the RAM at its pins. It commits bytes only when the overlap of chip select, write strobe and a byte enable ends, so a design that ended the write on chip select or on a byte enable would be flagged as having the wrong terminating edge, and a lane enabled against the mask would corrupt the neighbour byte. Empty-mask requests and requests issued back to back in the `done` cycle are aimed at the two places where a sequencer is most likely to slip. The first would emit a stray strobe or a late `done`. The second would shorten the cycle between chip-select falls, or move the address while chip select is still low. Data that is released at the rising edge, or driven for too few cycles before it, shows up as a short stable window or a changed hold value.

// File: rtl/sram_wr_pkg.sv
`timescale 1ns/1ps
package sram_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WE_LOW,
        ST_DRIVE,
        ST_RELEASE,
        ST_RECOVER
    } wr_state_e;

    // Round a nanosecond figure up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wr_timer.sv
`timescale 1ns/1ps
module sram_wr_timer #(
    parameter int unsigned TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sram_wr_lane.sv
`timescale 1ns/1ps
module sram_wr_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       mask_in,
    input  logic [7:0] byte_in,
    input  logic       win_nxt,
    output logic       be_n,
    output logic [7:0] byte_q
);
    logic mask_q;
    logic mask_use;

    // On the accepting edge the new mask must already steer the enable.
    assign mask_use = load ? mask_in : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            byte_q <= '0;
            be_n   <= 1'b1;
        end else begin
            if (load) begin
                mask_q <= mask_in;
                byte_q <= byte_in;
            end
            be_n <= !(win_nxt && mask_use);
        end
    end

endmodule

// File: rtl/sram_wr_fsm.sv
`timescale 1ns/1ps
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int unsigned HZ_CYC  = 2,
    parameter int unsigned DRV_CYC = 3,
    parameter int unsigned REC_CYC = 1,
    parameter int unsigned TW      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mask_any,
    output logic req_ready,
    output logic accept,
    output logic done,
    output logic ce_n,
    output logic we_n,
    output logic drv_en,
    output logic win_nxt
);
    wr_state_e     st, st_nxt;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    sram_wr_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Transitions and timer loads
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_IDLE: begin
                if (accept && mask_any) st_nxt = ST_SETUP;
            end
            ST_SETUP: begin
                st_nxt   = ST_WE_LOW;
                tmr_load = 1'b1;
                tmr_val  = TW'(HZ_CYC - 1);
            end
            ST_WE_LOW: begin
                if (tmr_zero) begin
                    st_nxt   = ST_DRIVE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(DRV_CYC - 1);
                end
            end
            ST_DRIVE: begin
                if (tmr_zero) st_nxt = ST_RELEASE;
            end
            ST_RELEASE: begin
                st_nxt   = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = TW'(REC_CYC - 1);
            end
            ST_RECOVER: begin
                if (tmr_zero) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign win_nxt = (st_nxt == ST_SETUP)  || (st_nxt == ST_WE_LOW) ||
                     (st_nxt == ST_DRIVE)  || (st_nxt == ST_RELEASE);

    // Registered pin strobes, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n   <= 1'b1;
            we_n   <= 1'b1;
            drv_en <= 1'b0;
            done   <= 1'b0;
        end else begin
            ce_n   <= !win_nxt;
            we_n   <= !((st_nxt == ST_WE_LOW) || (st_nxt == ST_DRIVE));
            drv_en <= (st_nxt == ST_DRIVE) || (st_nxt == ST_RELEASE);
            done   <= ((st == ST_RECOVER) && tmr_zero) || (accept && !mask_any);
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mask_any) |=> !req_ready);                                   // R2
    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !mask_any) |=> (done && ce_n && we_n));                      // R4

endmodule

// File: rtl/sram_wr_seq.sv
`timescale 1ns/1ps
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned LANES     = 2,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_WC_NS   = 45,
    parameter int unsigned T_PWE_NS  = 35,
    parameter int unsigned T_SD_NS   = 25,
    parameter int unsigned T_HZ_NS   = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [8*LANES-1:0]   req_data,
    input  logic [LANES-1:0]     req_mask,
    output logic                 done,
    output logic [ADDR_W-1:0]    sram_addr,
    inout  wire  [8*LANES-1:0]   sram_dq,
    output logic                 sram_ce_n,
    output logic                 sram_we_n,
    output logic                 sram_oe_n,
    output logic [LANES-1:0]     sram_be_n
);
    localparam int unsigned DATA_W  = 8 * LANES;
    localparam int unsigned HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned SD_CYC  = ns_to_cyc(T_SD_NS, CLK_NS);
    localparam int unsigned PWE_CYC = ns_to_cyc(T_PWE_NS, CLK_NS);
    localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned DRV_CYC = umax(SD_CYC, (PWE_CYC > HZ_CYC) ? PWE_CYC - HZ_CYC : 1);
    localparam int unsigned USED    = 2 + HZ_CYC + DRV_CYC;
    localparam int unsigned REC_CYC = (WC_CYC > USED) ? WC_CYC - USED : 1;
    localparam int unsigned TW      = $clog2(umax(umax(HZ_CYC, DRV_CYC), REC_CYC) + 1) + 1;
    localparam int unsigned CW      = $clog2(PWE_CYC + HZ_CYC + DRV_CYC + 2) + 1;

    logic              accept;
    logic              mask_any;
    logic              load;
    logic              drv_en;
    logic              win_nxt;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] addr_q;
    logic [CW-1:0]     we_lo_cnt;

    assign mask_any = |req_mask;
    assign load     = accept && mask_any;

    sram_wr_fsm #(
        .HZ_CYC  (HZ_CYC),
        .DRV_CYC (DRV_CYC),
        .REC_CYC (REC_CYC),
        .TW      (TW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .mask_any  (mask_any),
        .req_ready (req_ready),
        .accept    (accept),
        .done      (done),
        .ce_n      (sram_ce_n),
        .we_n      (sram_we_n),
        .drv_en    (drv_en),
        .win_nxt   (win_nxt)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_wr_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .mask_in (req_mask[g]),
            .byte_in (req_data[8*g +: 8]),
            .win_nxt (win_nxt),
            .be_n    (sram_be_n[g]),
            .byte_q  (wr_data[8*g +: 8])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= req_addr;
    end

    assign sram_addr = addr_q;
    assign sram_oe_n = 1'b1;
    assign sram_dq   = drv_en ? wr_data : {DATA_W{1'bz}};

    // Length of the current low strobe, used by the timing checks below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             we_lo_cnt <= '0;
        else if (sram_we_n)                     we_lo_cnt <= '0;
        else if (we_lo_cnt != {CW{1'b1}})       we_lo_cnt <= we_lo_cnt + 1'b1;
    end

    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (32'(we_lo_cnt) >= PWE_CYC));                      // R5
    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && (sram_be_n != {LANES{1'b1}})));            // R6
    AST_CE_HOLDS_PAST_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && (sram_be_n != {LANES{1'b1}})));      // R6
    AST_DRIVE_AFTER_HZ: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !sram_we_n) |-> (32'(we_lo_cnt) >= HZ_CYC));                 // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));               // R8

endmodule

// File: tb/sram_wr_seq_test.sv
`timescale 1ns/1ps
module sram_wr_seq_test;
    localparam int ADDR_W = 18;
    localparam int LAT    = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0]       req_data = '0;
    logic [1:0]        req_mask = '0;
    logic              done;
    logic [ADDR_W-1:0] sram_addr;
    wire  [15:0]       sram_dq;
    logic              sram_ce_n, sram_we_n, sram_oe_n;
    logic [1:0]        sram_be_n;

    int errors = 0;
    int checks = 0;

    sram_wr_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask), .done(done),
        .sram_addr(sram_addr), .sram_dq(sram_dq), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n)
    );

    always #5 clk = ~clk;

    function automatic int cyc_of(int ns);
        return (ns + 9) / 10;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // RAM model and reference memory
    logic [15:0] model_mem [32];
    logic [15:0] ref_mem   [32];

    // Pin monitor state
    logic        p_ce = 1, p_we = 1, p_active = 0;
    logic [1:0]  p_be = 2'b11;
    logic [15:0] p_dq = '0;
    logic [4:0]  p_addr = '0;
    int          we_len = 0, stab = 0, cyc = 0, last_fall = 0;
    bit          have_fall = 0;
    logic [1:0]  cur_mask = '0;
    bit          lane_bad = 0, oe_bad = 0, addr_bad = 0, strobe_seen = 0;

    always @(negedge clk) begin
        logic active;
        if (rst_n) begin
            cyc++;
            active = !sram_ce_n && !sram_we_n && (sram_be_n != 2'b11);
            if (sram_oe_n !== 1'b1) oe_bad = 1;
            if (!sram_ce_n || !sram_we_n || sram_be_n != 2'b11) strobe_seen = 1;
            if (!sram_ce_n && sram_be_n != ~cur_mask) lane_bad = 1;
            if (!sram_ce_n && !p_ce && sram_addr[4:0] != p_addr) addr_bad = 1;
            if (p_ce && !sram_ce_n) begin
                if (have_fall) chk(cyc - last_fall >= cyc_of(45), "R8", "chip select spacing",
                                   32'(cyc - last_fall), 32'(cyc_of(45)));
                last_fall = cyc;
                have_fall = 1;
            end
            if (p_we && !sram_we_n)
                chk(!sram_ce_n && sram_be_n != 2'b11, "R6", "select low before strobe falls",
                    {29'd0, sram_ce_n, sram_be_n}, 32'd0);
            if (p_active && !active) begin
                chk(sram_we_n && !sram_ce_n && sram_be_n == p_be, "R6", "write ended by strobe rise",
                    {28'd0, sram_we_n, sram_ce_n, sram_be_n}, {28'd0, 2'b10, p_be});
                chk(we_len >= cyc_of(35), "R5", "strobe low cycles", 32'(we_len), 32'(cyc_of(35)));
                chk(stab >= cyc_of(25), "R7", "data setup cycles", 32'(stab), 32'(cyc_of(25)));
                chk(sram_dq == p_dq, "R7", "data hold after rise", 32'(sram_dq), 32'(p_dq));
                if (!p_be[0]) model_mem[p_addr][7:0]  = p_dq[7:0];
                if (!p_be[1]) model_mem[p_addr][15:8] = p_dq[15:8];
            end
            we_len = sram_we_n ? 0 : we_len + 1;
            if (active) stab = (p_active && sram_dq == p_dq) ? stab + 1 : 1;
            else        stab = 0;
            p_ce = sram_ce_n; p_we = sram_we_n; p_be = sram_be_n;
            p_dq = sram_dq; p_active = active; p_addr = sram_addr[4:0];
        end
    end

    // Called at a negedge; returns at the negedge of the done cycle
    task automatic do_write(input logic [4:0] a, input logic [15:0] d, input logic [1:0] m);
        int  k;
        bit  done_seen, ready_bad;
        req_valid = 1'b1;
        req_addr  = {{(ADDR_W-5){1'b0}}, a};
        req_data  = d;
        req_mask  = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        cur_mask = m; lane_bad = 0; oe_bad = 0; addr_bad = 0; strobe_seen = 0;
        k = 0; done_seen = 0; ready_bad = 0;
        while (k < 40 && !done_seen) begin
            @(negedge clk);
            k++;
            if (k == 1) req_valid = 1'b0;
            if (done) done_seen = 1;
            else if (req_ready) ready_bad = 1;
        end
        chk(done_seen && k == ((m == 0) ? 1 : LAT), (m == 0) ? "R4" : "R9", "done latency",
            32'(k), 32'((m == 0) ? 1 : LAT));
        chk(!ready_bad, "R2", "ready low while busy", {31'd0, ready_bad}, 32'd0);
        if (m == 0) begin
            chk(!strobe_seen, "R4", "no strobe on empty mask", {31'd0, strobe_seen}, 32'd0);
        end else begin
            chk(!lane_bad, "R3", "byte enables follow mask", {31'd0, lane_bad}, 32'd0);
            chk(!oe_bad, "R5", "output enable held high", {31'd0, oe_bad}, 32'd0);
            chk(!addr_bad, "R8", "address stable under select", {31'd0, addr_bad}, 32'd0);
        end
        if (m[0]) ref_mem[a][7:0]  = d[7:0];
        if (m[1]) ref_mem[a][15:8] = d[15:8];
        chk(model_mem[a] == ref_mem[a], "R10", "stored word", 32'(model_mem[a]), 32'(ref_mem[a]));
    endtask

    initial begin
        int seed;
        for (int i = 0; i < 32; i++) begin model_mem[i] = '0; ref_mem[i] = '0; end
        seed = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        chk(req_ready && !done && sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == 2'b11,
            "R1", "state during reset", {26'd0, req_ready, done, sram_ce_n, sram_we_n, sram_be_n},
            {26'd0, 6'b101111});
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == 2'b11,
            "R1", "state after reset", {26'd0, req_ready, done, sram_ce_n, sram_we_n, sram_be_n},
            {26'd0, 6'b101111});
        // Directed corners, issued back to back
        do_write(5'd3, 16'hA1B2, 2'b11);
        do_write(5'd3, 16'h00C4, 2'b01);   // R3 lower lane only
        do_write(5'd3, 16'h5D00, 2'b10);   // R3 upper lane only
        do_write(5'd3, 16'hFFFF, 2'b00);   // R4 empty mask
        do_write(5'd7, 16'h1234, 2'b00);   // R4 second empty in a row
        do_write(5'd7, 16'h0F0F, 2'b11);
        do_write(5'd8, 16'hF0F0, 2'b11);   // R8 back-to-back address change
        repeat (2) @(negedge clk);
        do_write(5'd31, 16'hBEEF, 2'b10);
        // Random traffic
        for (int i = 0; i < 40; i++)
            do_write(5'($urandom % 32), 16'($urandom), 2'($urandom % 4));
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule